// File: doc/BRIEF.md
# Tokened Three-Level Channel Arbiter

This block decides which of eight DMA channels may drive one shared bus address port, read or write. Each channel presents a request line, a two-bit priority level and a token count. When the port is free, the arbiter picks the requester with the highest level. Ties among equal levels are broken by a rotating pointer that starts just after the channel that won last.

The winner keeps the port for a window of accepted address handshakes. The window lasts for as many handshakes as the winner's token count allows. It ends early if the winner withdraws its request. A Top request that arrives mid-window waits until the window closes. Read and write traffic each use their own instance, so each direction has its own priority and token settings.

The grant is registered. It is shown both as a one-hot vector and as a channel index with a valid flag. Between two windows there is always one cycle with no grant, during which the next winner is chosen. The channel count must be a power of two.

Top module: `chanTokenArb`

## Requirements
- R1: After reset, and while no channel requests, grantValid is 0 and grantOneHot is all zeros.
- R2: At most one bit of grantOneHot is set, and while grantValid is 1 the set bit is the one at position grantIdx.
- R3: The priority code is 0 = Normal, 1 = High, 2 = Top, and 3 is treated as Top. When the port is free, the granted channel is always a requester at the highest level present.
- R4: Among requesters at the winning level, the pick is the first one found searching upward (wrapping) from the channel after the last winner. After reset, the search starts at channel 0.
- R5: A window allows exactly token-count accepted handshakes, where a handshake is addrFire high while the owner requests. The grant drops in the cycle after the last one, and a pending request is granted in the cycle after that.
- R6: A token count of 0 gives a window of one handshake.
- R7: If the owner drops its request, the grant is removed on the next clock edge, even with tokens left.
- R8: During a window, the grant does not move to another channel, even a newly requesting Top one, until the tokens are used or the owner's request drops.
- R9: A new grant goes only to a channel that requested on the previous edge, and appears one edge after a request is seen on a free port. addrFire pulses while nothing is granted have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | N_CH | Per-channel request lines |
| prioVec | input | 2*N_CH | Per-channel level; channel i uses bits [2i+1:2i] |
| tokenVec | input | TOK_W*N_CH | Per-channel token count; channel i uses bits [TOK_W*i +: TOK_W] |
| addrFire | input | 1 | Address handshake accepted this cycle (valid and ready both high) |
| grantOneHot | output | N_CH | One-hot grant, all zeros when nothing is granted |
| grantIdx | output | $clog2(N_CH) | Current or most recent owner index (N_CH-1 after reset) |
| grantValid | output | 1 | A window is open |

## Verification
The checker assumes two things about the inputs. First, the owner's token count stays unchanged for the length of its window, since the window limit is rebuilt from the live token input. Second, addrFire describes the handshake of the granted channel only.

The stimulus changes priorities and token counts only while no window is open or for channels that do not own the port. It pulses addrFire either while a grant is held or deliberately on an idle port, to show that such pulses are ignored.

// File: rtl/tokArbPkg.sv
package tokArbPkg;
  typedef enum logic [1:0] {
    LVL_NORMAL = 2'd0,
    LVL_HIGH   = 2'd1,
    LVL_TOP    = 2'd2,
    LVL_TOP_ALT = 2'd3
  } prioLvl_e;

  typedef struct packed {
    logic startWin;
    logic useToken;
    logic endWin;
  } arbStrobe_t;
endpackage

// File: rtl/tokArbDp.sv
module tokArbDp
  import tokArbPkg::*;
#(
  parameter int N_CH  = 8,
  parameter int TOK_W = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N_CH-1:0]       reqVec,
  input  logic [2*N_CH-1:0]     prioVec,
  input  logic [TOK_W*N_CH-1:0] tokenVec,
  input  arbStrobe_t            strb,
  output logic                  anyReq,
  output logic                  ownerReq,
  output logic                  tokLast,
  output logic [IDX_W-1:0]      ownerIdx
);
  logic [1:0]       effLvl [N_CH];
  logic [TOK_W-1:0] tokArr [N_CH];
  logic [N_CH-1:0]  cand;
  logic [1:0]       topLvl;
  logic [IDX_W-1:0] pickIdx;
  logic [IDX_W-1:0] slot;
  logic             found;
  logic [TOK_W-1:0] pickTok;
  logic [TOK_W-1:0] tokLeft;

  // per-channel level folding (code 3 counts as Top) and token slicing
  for (genvar g = 0; g < N_CH; g++) begin : gChan
    assign effLvl[g] = (prioVec[2*g +: 2] == LVL_TOP_ALT) ? LVL_TOP : prioVec[2*g +: 2];
    assign tokArr[g] = tokenVec[TOK_W*g +: TOK_W];
    assign cand[g]   = reqVec[g] && (effLvl[g] == topLvl);
  end

  // highest level present among requesters
  always_comb begin
    topLvl = LVL_NORMAL;
    anyReq = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (reqVec[i]) begin
        anyReq = 1'b1;
        if (effLvl[i] > topLvl) topLvl = effLvl[i];
      end
    end
  end

  // rotating search starting after the last winner
  always_comb begin
    pickIdx = '0;
    found   = 1'b0;
    slot    = '0;
    for (int j = 1; j <= N_CH; j++) begin
      slot = ownerIdx + IDX_W'(j);
      if (!found && cand[slot]) begin
        found   = 1'b1;
        pickIdx = slot;
      end
    end
  end

  assign pickTok  = tokArr[pickIdx];
  assign ownerReq = reqVec[ownerIdx];
  assign tokLast  = (tokLeft == TOK_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerIdx <= IDX_W'(N_CH - 1);
      tokLeft  <= '0;
    end else if (strb.startWin) begin
      ownerIdx <= pickIdx;
      tokLeft  <= (pickTok == '0) ? TOK_W'(1) : pickTok;
    end else if (strb.useToken) begin
      tokLeft  <= tokLeft - TOK_W'(1);
    end
  end
endmodule

// File: rtl/tokArbCtl.sv
module tokArbCtl
  import tokArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       ownerReq,
  input  logic       tokLast,
  input  logic       addrFire,
  output arbStrobe_t strb,
  output logic       busy
);
  always_comb begin
    strb.startWin = !busy && anyReq;
    strb.useToken = busy && addrFire && ownerReq;
    strb.endWin   = busy && (!ownerReq || (addrFire && tokLast));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busy <= 1'b0;
    else if (strb.startWin) busy <= 1'b1;
    else if (strb.endWin)   busy <= 1'b0;
  end
endmodule

// File: rtl/chanTokenArb.sv
module chanTokenArb
  import tokArbPkg::*;
#(
  parameter int N_CH  = 8,
  parameter int TOK_W = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N_CH-1:0]       reqVec,
  input  logic [2*N_CH-1:0]     prioVec,
  input  logic [TOK_W*N_CH-1:0] tokenVec,
  input  logic                  addrFire,
  output logic [N_CH-1:0]       grantOneHot,
  output logic [IDX_W-1:0]      grantIdx,
  output logic                  grantValid
);
  arbStrobe_t       strb;
  logic             anyReq;
  logic             ownerReq;
  logic             tokLast;
  logic             busy;
  logic [IDX_W-1:0] ownerIdx;

  tokArbDp #(.N_CH(N_CH), .TOK_W(TOK_W)) uDp (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .tokenVec(tokenVec), .strb(strb), .anyReq(anyReq),
    .ownerReq(ownerReq), .tokLast(tokLast), .ownerIdx(ownerIdx)
  );

  tokArbCtl uCtl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .ownerReq(ownerReq),
    .tokLast(tokLast), .addrFire(addrFire), .strb(strb), .busy(busy)
  );

  for (genvar g = 0; g < N_CH; g++) begin : gOneHot
    assign grantOneHot[g] = busy && (ownerIdx == IDX_W'(g));
  end

  assign grantIdx   = ownerIdx;
  assign grantValid = busy;
endmodule

// File: rtl/chanTokenArbChk.sv
module chanTokenArbChk #(
  parameter int N_CH  = 8,
  parameter int TOK_W = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [N_CH-1:0]       reqVec,
  input logic [TOK_W*N_CH-1:0] tokenVec,
  input logic                  addrFire,
  input logic [N_CH-1:0]       grantOneHot,
  input logic [IDX_W-1:0]      grantIdx,
  input logic                  grantValid
);
  logic [TOK_W-1:0] tokArr [N_CH];
  logic [TOK_W:0]   fireCnt;
  logic [TOK_W:0]   winLim;
  logic [N_CH-1:0]  reqQ;
  logic             validQ;
  logic             ownFire;

  for (genvar g = 0; g < N_CH; g++) begin : gTok
    assign tokArr[g] = tokenVec[TOK_W*g +: TOK_W];
  end

  assign winLim  = (tokArr[grantIdx] == '0) ? (TOK_W+1)'(1) : {1'b0, tokArr[grantIdx]};
  assign ownFire = grantValid && addrFire && reqVec[grantIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fireCnt <= '0;
      reqQ    <= '0;
      validQ  <= 1'b0;
    end else begin
      reqQ    <= reqVec;
      validQ  <= grantValid;
      if (!grantValid)  fireCnt <= '0;
      else if (ownFire) fireCnt <= fireCnt + (TOK_W+1)'(1);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot)); // R2
  AST_GRANT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (grantOneHot[grantIdx] && $countones(grantOneHot) == 1)); // R2
  AST_TOKEN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (fireCnt < winLim)); // R5
  AST_WINDOW_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (ownFire && (fireCnt + (TOK_W+1)'(1) == winLim)) |=> !grantValid); // R5
  AST_DROP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !reqVec[grantIdx]) |=> !grantValid); // R7
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && reqVec[grantIdx] && !addrFire) |=> (grantValid && $stable(grantIdx))); // R8
  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !validQ) |-> reqQ[grantIdx]); // R9
endmodule

bind chanTokenArb chanTokenArbChk #(.N_CH(N_CH), .TOK_W(TOK_W)) uChk (.*);

// File: tb/tb_chanTokenArb.sv
module tb_chanTokenArb;
  localparam int N_CH  = 8;
  localparam int TOK_W = 4;
  localparam int IDX_W = $clog2(N_CH);

  typedef struct {
    int    idx;
    string tag;
  } expItem_t;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [N_CH-1:0]       reqVec = '0;
  logic [2*N_CH-1:0]     prioVec = '0;
  logic [TOK_W*N_CH-1:0] tokenVec = '0;
  logic                  addrFire = 1'b0;
  logic [N_CH-1:0]       grantOneHot;
  logic [IDX_W-1:0]      grantIdx;
  logic                  grantValid;

  int       checks = 0;
  int       failures = 0;
  bit       done = 1'b0;
  expItem_t expQ[$];
  expItem_t item;
  logic     prevV = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  chanTokenArb #(.N_CH(N_CH), .TOK_W(TOK_W)) dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .tokenVec(tokenVec), .addrFire(addrFire), .grantOneHot(grantOneHot),
    .grantIdx(grantIdx), .grantValid(grantValid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expectGrant(input int idx, input string tag);
    expItem_t e;
    e.idx = idx;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic waitGrant(input string tag);
    int n = 0;
    tick();
    while (!grantValid && n < 100) begin
      tick();
      n++;
    end
    check(grantValid, tag, int'(grantValid), 1);
  endtask

  task automatic dropAndCheck(input int ch, input string tag);
    @(negedge clk);
    reqVec[ch] = 1'b0;
    tick();
    check(!grantValid, tag, int'(grantValid), 0);
  endtask

  // scoreboard monitor: every new window must match the next expected owner
  initial begin : monitor
    forever begin
      tick();
      if (grantValid && !prevV) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected grant", int'(grantIdx), -1);
        end else begin
          item = expQ.pop_front();
          check(int'(grantIdx) == item.idx, item.tag, int'(grantIdx), item.idx);
          check(grantOneHot == (N_CH'(1) << item.idx), "R2 one-hot vs index",
                int'(grantOneHot), 1 << item.idx);
        end
      end
      prevV = grantValid;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    for (int c = 0; c < N_CH; c++) tokenVec[TOK_W*c +: TOK_W] = 4'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tick();
    check(!grantValid, "R1 valid after reset", int'(grantValid), 0);
    check(grantOneHot == '0, "R1 one-hot after reset", int'(grantOneHot), 0);

    // R3: levels Normal(2), High(5), Top(6)
    @(negedge clk);
    prioVec[4 +: 2] = 2'd0; prioVec[10 +: 2] = 2'd1; prioVec[12 +: 2] = 2'd2;
    reqVec = 8'b0110_0100;
    expectGrant(6, "R3 Top beats High and Normal");
    waitGrant("R3 grant seen");
    expectGrant(5, "R3 High beats Normal");
    dropAndCheck(6, "R7 early release on drop");
    waitGrant("R3 second grant");
    expectGrant(2, "R3 Normal last");
    dropAndCheck(5, "R7 early release on drop");
    waitGrant("R3 third grant");
    dropAndCheck(2, "R7 early release on drop");

    // R3 code 3 is Top, R4 rotation after last winner (2)
    @(negedge clk);
    prioVec = '0;
    prioVec[2 +: 2] = 2'd3; prioVec[8 +: 2] = 2'd2; prioVec[0 +: 2] = 2'd1;
    reqVec = 8'b0001_0011;
    expectGrant(4, "R4 rotation picks 4 after 2");
    waitGrant("R4 grant seen");
    expectGrant(1, "R3 code 3 counts as Top");
    dropAndCheck(4, "R7 early release on drop");
    waitGrant("R3 grant seen");
    expectGrant(0, "R3 High after Tops gone");
    dropAndCheck(1, "R7 early release on drop");
    waitGrant("R3 grant seen");
    dropAndCheck(0, "R7 early release on drop");

    // R4: all Normal, one token each, last winner 0
    @(negedge clk);
    prioVec = '0;
    for (int c = 0; c < N_CH; c++) tokenVec[TOK_W*c +: TOK_W] = 4'd1;
    for (int k = 1; k <= N_CH; k++) expectGrant(k % N_CH, "R4 round robin order");
    reqVec = '1;
    for (int k = 1; k <= N_CH; k++) begin
      waitGrant("R4 grant seen");
      @(negedge clk);
      addrFire = 1'b1;
      @(negedge clk);
      addrFire = 1'b0;
      if (k == N_CH) reqVec = '0;
    end
    tick();
    check(!grantValid, "R4 idle after rotation", int'(grantValid), 0);

    // R5: token window of 3, then re-grant
    @(negedge clk);
    tokenVec[TOK_W*3 +: TOK_W] = 4'd3;
    reqVec = 8'b0000_1000;
    expectGrant(3, "R5 first window");
    expectGrant(3, "R5 re-grant after gap");
    waitGrant("R5 grant seen");
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      addrFire = 1'b1;
      tick();
      check(grantValid == (i < 3), "R5 window length", int'(grantValid), int'(i < 3));
    end
    @(negedge clk);
    addrFire = 1'b0;
    tick();
    check(grantValid && grantIdx == 3, "R5 re-arbitration one cycle after gap",
          int'(grantValid), 1);
    dropAndCheck(3, "R7 early release on drop");

    // R6: zero token count gives one handshake
    @(negedge clk);
    tokenVec[TOK_W*7 +: TOK_W] = 4'd0;
    reqVec = 8'b1000_0000;
    expectGrant(7, "R6 zero-token grant");
    waitGrant("R6 grant seen");
    @(negedge clk);
    addrFire = 1'b1;
    tick();
    check(!grantValid, "R6 zero token ends after one", int'(grantValid), 0);
    @(negedge clk);
    addrFire = 1'b0;
    reqVec = '0;

    // R8: Top arrival does not preempt a Normal window of 4
    @(negedge clk);
    tokenVec[TOK_W*0 +: TOK_W] = 4'd4;
    prioVec[10 +: 2] = 2'd2;
    reqVec = 8'b0000_0001;
    expectGrant(0, "R8 Normal owner");
    expectGrant(5, "R8 Top after window");
    waitGrant("R8 grant seen");
    @(negedge clk);
    reqVec[5] = 1'b1;
    tick();
    check(grantValid && grantIdx == 0, "R8 hold against Top", int'(grantIdx), 0);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      addrFire = 1'b1;
      tick();
      if (i < 4) check(grantValid && grantIdx == 0, "R8 no preemption",
                       int'(grantIdx), 0);
      else check(!grantValid, "R5 window closes after 4", int'(grantValid), 0);
    end
    @(negedge clk);
    addrFire = 1'b0;
    reqVec[0] = 1'b0;
    waitGrant("R8 Top granted");
    dropAndCheck(5, "R7 early release on drop");

    // R9: idle handshakes ignored, grant one edge after request
    @(negedge clk);
    prioVec = '0;
    addrFire = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(!grantValid, "R9 idle handshake no grant", int'(grantValid), 0);
    end
    @(negedge clk);
    addrFire = 1'b0;
    tokenVec[TOK_W*2 +: TOK_W] = 4'd2;
    reqVec = 8'b0000_0100;
    expectGrant(2, "R9 grant to requester");
    tick();
    check(grantValid && grantIdx == 2, "R9 grant one edge after request",
          int'(grantValid), 1);
    @(negedge clk);
    addrFire = 1'b1;
    tick();
    check(grantValid, "R9 idle handshakes spent no tokens", int'(grantValid), 1);
    tick();
    check(!grantValid, "R5 window of 2 closes", int'(grantValid), 0);
    @(negedge clk);
    addrFire = 1'b0;
    reqVec = '0;

    repeat (3) tick();
    check(expQ.size() == 0, "R2 all expected grants observed", expQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule